// File: doc/BRIEF.md
# Mode-Configurable Integer Divider

This block is a multicycle divider for 32-bit integers. A one-cycle start pulse hands it a dividend, a divisor, a select that picks either the quotient or the remainder, and an 8-bit policy byte. The policy byte chooses between two's-complement and unsigned arithmetic. It also chooses what happens in the two cases that have no defined result: a zero divisor, and the signed most-negative value divided by minus one. In each of these two cases the block can trap with an exception code, or it can substitute a fixed minimum, zero or maximum value.

Ordinary operands go through a radix-2 restoring loop of 32 iterations. One setup cycle before the loop takes operand magnitudes, and one fix-up cycle after it restores the signs. The two exceptional cases skip the loop and finish at once. The block returns a one-cycle done pulse. With that pulse it gives either a valid result or an exception, plus carry and overflow indications for the flag logic outside the block.

Top module: `mdiv_top`

## Requirements
- R1: With policy bit 4 clear, operands are unsigned and the result is floor(dividend / divisor), or dividend mod divisor when the remainder is selected.
- R2: With policy bit 4 set, operands are two's complement, the quotient truncates toward zero and a nonzero remainder carries the sign of the dividend.
- R3: A zero divisor with policy bits [3:2] = 00 raises the exception output with code 0x0A, and the result reads 0.
- R4: A zero divisor with policy bits [3:2] = 01, 10 or 11 returns the minimum, zero or maximum value. Minimum and maximum are 0x80000000 and 0x7FFFFFFF in signed mode and 0x00000000 and 0xFFFFFFFF in unsigned mode.
- R5: In signed mode, dividend 0x80000000 with divisor 0xFFFFFFFF and policy bits [1:0] = 00 raises the exception output with code 0x0B.
- R6: That same signed overflow case with policy bits [1:0] = 01, 10 or 11 returns the minimum, zero or maximum value of R4.
- R7: Carry and overflow outputs are both high exactly when a substitute value of R4 or R6 is returned, and both low otherwise.
- R8: When the remainder is selected, the zero-divisor and overflow cases follow the same policy fields, substitute values and exception codes as the quotient.
- R9: In unsigned mode, 0x80000000 divided by 0xFFFFFFFF is an ordinary division (quotient 0, remainder 0x80000000), with no exception and no flags.
- R10: For a special case, done rises on the clock edge that samples start. For an ordinary division, done rises 34 edges after that sampling edge.
- R11: A start pulse that arrives while a division is in progress is ignored, and the operands of the running division are kept.
- R12: Done is a one-cycle pulse per accepted start, and result-valid is high with done only when no exception is raised.
- R13: After reset, done, result-valid, exception, carry, overflow and result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request, taken only when idle |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| rem_sel_i | input | 1 | 1 returns the remainder, 0 the quotient |
| policy_i | input | 8 | Bit 4 signed; [3:2] zero-divisor policy; [1:0] overflow policy |
| result_o | output | 32 | Quotient, remainder or substitute value |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Result is valid (done without exception) |
| carry_o | output | 1 | Carry indication for a substitution |
| ovf_o | output | 1 | Overflow indication for a substitution |
| exc_o | output | 1 | Exception raised with done |
| exc_code_o | output | 8 | Exception code (0x0A or 0x0B) |

## Verification
The hardest situation to reach from the ports is a second start that arrives in the middle of the 32-iteration loop while the operand inputs already hold different values. A restart, or a reload of the operands, would be hidden unless the original result and its latency are both checked. The stimulus launches an ordinary division and holds it in the loop. A few cycles later it pulses start again with new operands and no expected entry, so a wrong restart shows up as a changed result or a changed latency in the scoreboard. The signed overflow corner is driven once under each of its four policies, with both quotient and remainder selected. The same bit pattern is also driven in unsigned mode.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;

    typedef struct packed {
        logic [2:0] spare;
        logic       is_signed;
        logic [1:0] on_zero;
        logic [1:0] on_ovf;
    } policy_t;

    typedef enum logic [1:0] {
        POL_TRAP = 2'd0,
        POL_MIN  = 2'd1,
        POL_ZERO = 2'd2,
        POL_MAX  = 2'd3
    } subst_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ITER,
        ST_FIX
    } state_e;

    localparam logic [7:0] EXC_ZERO_DIV = 8'h0A;
    localparam logic [7:0] EXC_OVF_DIV  = 8'h0B;

endpackage

// File: rtl/mdiv_special.sv
module mdiv_special
    import mdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    input  policy_t      pol,
    output logic         hit,
    output logic         trap,
    output logic [7:0]   code,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    logic       is_zero;
    logic       is_ovf;
    subst_e     choice;
    logic       unused_spare;

    assign unused_spare = ^pol.spare;
    assign is_zero = (den == '0);
    assign is_ovf  = pol.is_signed && (num == MOST_NEG) && (den == '1);
    assign hit     = is_zero || is_ovf;
    assign choice  = is_zero ? subst_e'(pol.on_zero) : subst_e'(pol.on_ovf);
    assign trap    = hit && (choice == POL_TRAP);
    assign code    = is_zero ? EXC_ZERO_DIV : EXC_OVF_DIV;

    always_comb begin
        unique case (choice)
            POL_MIN:  value = pol.is_signed ? MOST_NEG : '0;
            POL_MAX:  value = pol.is_signed ? MOST_POS : '1;
            default:  value = '0;
        endcase
    end

endmodule

// File: rtl/mdiv_core.sv
module mdiv_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         last
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  quo_q, rem_q, den_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    shifted;
    logic [W:0]    diff;

    assign shifted = {rem_q, quo_q[W-1]};
    assign diff    = shifted - {1'b0, den_q};
    assign last    = (cnt_q == CW'(1));
    assign quo     = quo_q;
    assign rem     = rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q <= '0;
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            quo_q <= num;
            rem_q <= '0;
            den_q <= den;
            cnt_q <= CW'(W);
        end else if (cnt_q != '0) begin
            if (!diff[W]) begin
                rem_q <= diff[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // R1: partial remainder stays below the divisor through every step
    p_rem_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && !load && den_q != '0) |=> (rem_q < den_q));

endmodule

// File: rtl/mdiv_top.sv
module mdiv_top
    import mdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    input  logic         rem_sel_i,
    input  logic [7:0]   policy_i,
    output logic [W-1:0] result_o,
    output logic         done_o,
    output logic         valid_o,
    output logic         carry_o,
    output logic         ovf_o,
    output logic         exc_o,
    output logic [7:0]   exc_code_o
);
    state_e       state_q;
    policy_t      pol;
    logic         sp_hit, sp_trap;
    logic [7:0]   sp_code;
    logic [W-1:0] sp_value;

    logic [W-1:0] num_q, den_q;
    logic         rem_sel_q, sgn_q;
    logic         core_load, core_last;
    logic [W-1:0] core_quo, core_rem;
    logic [W-1:0] num_mag, den_mag;
    logic         neg_quo, neg_rem;
    logic [W-1:0] pick;

    logic [W-1:0] result_q;
    logic         done_q, valid_q, flag_q, exc_q;
    logic [7:0]   code_q;

    assign pol = policy_t'(policy_i);

    mdiv_special #(.W(W)) u_special (
        .num   (dividend_i),
        .den   (divisor_i),
        .pol   (pol),
        .hit   (sp_hit),
        .trap  (sp_trap),
        .code  (sp_code),
        .value (sp_value)
    );

    assign num_mag   = (sgn_q && num_q[W-1]) ? -num_q : num_q;
    assign den_mag   = (sgn_q && den_q[W-1]) ? -den_q : den_q;
    assign neg_quo   = sgn_q && (num_q[W-1] ^ den_q[W-1]);
    assign neg_rem   = sgn_q && num_q[W-1];
    assign core_load = (state_q == ST_SETUP);
    assign pick      = rem_sel_q ? core_rem : core_quo;

    mdiv_core #(.W(W)) u_core (
        .clk  (clk),
        .rst  (rst),
        .load (core_load),
        .num  (num_mag),
        .den  (den_mag),
        .quo  (core_quo),
        .rem  (core_rem),
        .last (core_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            num_q     <= '0;
            den_q     <= '0;
            rem_sel_q <= 1'b0;
            sgn_q     <= 1'b0;
            result_q  <= '0;
            done_q    <= 1'b0;
            valid_q   <= 1'b0;
            flag_q    <= 1'b0;
            exc_q     <= 1'b0;
            code_q    <= '0;
        end else begin
            done_q  <= 1'b0;
            valid_q <= 1'b0;
            flag_q  <= 1'b0;
            exc_q   <= 1'b0;
            code_q  <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (sp_hit) begin
                            done_q   <= 1'b1;
                            exc_q    <= sp_trap;
                            valid_q  <= !sp_trap;
                            flag_q   <= !sp_trap;
                            code_q   <= sp_trap ? sp_code : 8'h00;
                            result_q <= sp_trap ? '0 : sp_value;
                        end else begin
                            num_q     <= dividend_i;
                            den_q     <= divisor_i;
                            rem_sel_q <= rem_sel_i;
                            sgn_q     <= pol.is_signed;
                            state_q   <= ST_SETUP;
                        end
                    end
                end
                ST_SETUP: state_q <= ST_ITER;
                ST_ITER: begin
                    if (core_last) state_q <= ST_FIX;
                end
                ST_FIX: begin
                    result_q <= (rem_sel_q ? neg_rem : neg_quo) ? -pick : pick;
                    done_q   <= 1'b1;
                    valid_q  <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign result_o   = result_q;
    assign done_o     = done_q;
    assign valid_o    = valid_q;
    assign carry_o    = flag_q;
    assign ovf_o      = flag_q;
    assign exc_o      = exc_q;
    assign exc_code_o = code_q;

    // R12: valid only accompanies a done without exception
    p_valid_with_done_r12: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (done_o && !exc_o));

    // R3: an exception carries one of the two defined codes
    p_exc_code_r3: assert property (@(posedge clk) disable iff (rst)
        exc_o |-> (done_o && (exc_code_o == EXC_ZERO_DIV || exc_code_o == EXC_OVF_DIV)));

    // R7: substitution flags only appear on a valid result
    p_flags_valid_r7: assert property (@(posedge clk) disable iff (rst)
        (carry_o || ovf_o) |-> valid_o);

    // R10: fix-up stage is entered only after the core finished its last step
    p_fix_after_core_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIX) |-> $past(core_last));

    // R11: start in the middle of a division does not return the FSM to setup
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ITER && !core_last) |=> (state_q == ST_ITER || state_q == ST_FIX));

endmodule

// File: tb/sim_mdiv_top.sv
module sim_mdiv_top;

    typedef struct {
        logic [31:0] res;
        logic        exc;
        logic [7:0]  code;
        logic        flag;
        int          lat;
        int          issued;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        rem_sel_i = 1'b0;
    logic [7:0]  policy_i = '0;
    logic [31:0] result_o;
    logic        done_o, valid_o, carry_o, ovf_o, exc_o;
    logic [7:0]  exc_code_o;

    item_t sb[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    always #2 clk = ~clk;

    mdiv_top u0 (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .rem_sel_i  (rem_sel_i),
        .policy_i   (policy_i),
        .result_o   (result_o),
        .done_o     (done_o),
        .valid_o    (valid_o),
        .carry_o    (carry_o),
        .ovf_o      (ovf_o),
        .exc_o      (exc_o),
        .exc_code_o (exc_code_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic item_t model(input logic [31:0] a, input logic [31:0] b,
                                    input logic rs, input logic [7:0] m, input string tag);
        item_t e;
        logic sg, z, ov;
        logic [1:0] p;
        sg = m[4];
        z  = (b == 32'h0);
        ov = sg && a == 32'h8000_0000 && b == 32'hFFFF_FFFF;
        e.tag = tag; e.exc = 1'b0; e.code = 8'h00; e.flag = 1'b0; e.res = '0;
        if (z || ov) begin
            e.lat = 1;
            p = z ? m[3:2] : m[1:0];
            case (p)
                2'd0: begin e.exc = 1'b1; e.code = z ? 8'h0A : 8'h0B; end
                2'd1: begin e.flag = 1'b1; e.res = sg ? 32'h8000_0000 : 32'h0; end
                2'd2: begin e.flag = 1'b1; e.res = 32'h0; end
                default: begin e.flag = 1'b1; e.res = sg ? 32'h7FFF_FFFF : 32'hFFFF_FFFF; end
            endcase
        end else begin
            e.lat = 35;
            if (sg) e.res = rs ? 32'($signed(a) % $signed(b)) : 32'($signed(a) / $signed(b));
            else    e.res = rs ? a % b : a / b;
        end
        return e;
    endfunction

    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic rs,
                       input logic [7:0] m, input string tag);
        item_t e;
        e = model(a, b, rs, m, tag);
        @(negedge clk);
        dividend_i = a; divisor_i = b; rem_sel_i = rs; policy_i = m; start_i = 1'b1;
        e.issued = cyc;
        sb.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11 unexpected done", result_o, 32'h0);
            end else begin
                item_t e;
                e = sb.pop_front();
                chk(result_o == e.res, e.tag, result_o, e.res);
                chk(exc_o == e.exc, {e.tag, " exc"}, 32'(exc_o), 32'(e.exc));
                chk(exc_code_o == e.code, {e.tag, " code"}, 32'(exc_code_o), 32'(e.code));
                chk(valid_o == !e.exc, {e.tag, " R12 valid"}, 32'(valid_o), 32'(!e.exc));
                chk(carry_o == e.flag && ovf_o == e.flag, {e.tag, " R7 flags"},
                    32'({carry_o, ovf_o}), 32'({e.flag, e.flag}));
                chk(cyc - e.issued == e.lat, {e.tag, " R10 latency"}, 32'(cyc - e.issued), 32'(e.lat));
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'(cyc), 32'h0);
        summary();
    end

    initial begin
        item_t e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done_o && !valid_o && !exc_o && !carry_o && !ovf_o && result_o == 0,
            "R13 reset state", {done_o, valid_o, exc_o, carry_o, ovf_o, 27'h0}, 32'h0);

        run(32'd100, 32'd7, 1'b0, 8'h00, "R1 unsigned quotient");
        run(32'd100, 32'd7, 1'b1, 8'h00, "R1 unsigned remainder");
        run(32'hFFFF_FFFF, 32'd3, 1'b0, 8'h00, "R1 large unsigned");
        run(32'hDEAD_BEEF, 32'h0001_2345, 1'b1, 8'h00, "R1 mixed remainder");
        run(-32'sd7, 32'd2, 1'b0, 8'h10, "R2 signed truncation");
        run(-32'sd7, 32'd2, 1'b1, 8'h10, "R2 remainder sign of dividend");
        run(32'd7, -32'sd2, 1'b1, 8'h10, "R2 positive dividend negative divisor");
        run(-32'sd100, -32'sd9, 1'b0, 8'h10, "R2 both negative");
        run(32'd5, 32'd0, 1'b0, 8'h10, "R3 zero trap signed");
        run(32'd5, 32'd0, 1'b0, 8'h00, "R3 zero trap unsigned");
        run(32'd5, 32'd0, 1'b0, 8'h14, "R4 zero gives signed min");
        run(32'd5, 32'd0, 1'b0, 8'h04, "R4 zero gives unsigned min");
        run(32'd5, 32'd0, 1'b0, 8'h18, "R4 zero gives zero");
        run(32'd5, 32'd0, 1'b0, 8'h1C, "R4 zero gives signed max");
        run(32'd5, 32'd0, 1'b0, 8'h0C, "R4 zero gives unsigned max");
        run(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 8'h10, "R5 overflow trap");
        run(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 8'h11, "R6 overflow gives min");
        run(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 8'h12, "R6 overflow gives zero");
        run(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 8'h13, "R6 overflow gives max");
        run(32'd9, 32'd0, 1'b1, 8'h10, "R8 remainder zero trap");
        run(32'd9, 32'd0, 1'b1, 8'h1C, "R8 remainder zero max");
        run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 8'h10, "R8 remainder overflow trap");
        run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 8'h11, "R8 remainder overflow min");
        run(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 8'h00, "R9 unsigned pattern quotient");
        run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 8'h03, "R9 unsigned pattern remainder");
        run(32'h8000_0000, 32'd1, 1'b0, 8'h10, "R2 most negative by one");

        // R11: second start while busy with new operands must be ignored
        e = model(32'd1000, 32'd33, 1'b0, 8'h00, "R11 busy start ignored");
        @(negedge clk);
        dividend_i = 32'd1000; divisor_i = 32'd33; rem_sel_i = 1'b0; policy_i = 8'h00; start_i = 1'b1;
        e.issued = cyc;
        sb.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        dividend_i = 32'd77; divisor_i = 32'd0; rem_sel_i = 1'b1; policy_i = 8'h10; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait (sb.size() == 0);
        repeat (40) @(negedge clk);
        chk(sb.size() == 0, "R11 no extra result", 32'(sb.size()), 32'h0);

        // R12: back-to-back special cases each give exactly one done
        run(32'd1, 32'd0, 1'b0, 8'h18, "R12 single done pulse");
        @(negedge clk);
        chk(!done_o, "R12 done drops", 32'(done_o), 32'h0);

        summary();
    end

endmodule